// File: doc/BRIEF.md
# Upset-Hardened Gold Sequence Register Bank

This block holds four independent 10-stage maximal-length shift registers of the kind that produce the first half of a satellite ranging code. Each one follows the recurrence of the polynomial 1 + x^3 + x^10. Every state bit is kept three times, so that a single-event upset in one copy neither corrupts the output chip nor survives for long. Four registers are provided because four satellites are the fewest that give a position fix. The rest of the receiver consumes the four chips and combines them with the code-phase logic that lies outside this block.

A parameter selects how much voting hardware is spent. In the all-stage mode, every bit position is majority-voted on each shift and the voted value moves on into all three copies. In the single-column mode only stage 3 is voted. The other stages shift their three copies independently, and the recirculating data carries any lone error to the voter within ten shifts. A counter of enabled shifts reloads every copy to all ones once per 1023-chip code period. An injection bus can flip any single copy of any bit, so the protection can be exercised in test.

Top module: `tmr_gold_bank`

## Requirements
- R1: A synchronous reset loads every copy of every stage with 1 and clears the shift counter. After reset the chips read all ones and no mismatch flag is set.
- R2: With no upsets, each enabled edge shifts stage k into stage k+1, and stage 1 receives stage 3 XOR stage 10. Each chip equals stage 10, starting from the all-ones state.
- R3: While `en` is low and nothing is injected, the state and the chips hold, and no mismatch flag is raised.
- R4: On the enabled edge that follows 1022 enabled shifts since reset or since the last reload, every copy of every lane is loaded with all ones, whatever its contents were. Only enabled edges advance the counter.
- R5: Bit `(lane*3 + copy)*10 + (stage-1)` of `upset_inj` inverts that one copy bit at the clock edge. The inversion is applied after that edge's shift or reload.
- R6: In the all-stage mode, a single upset never reaches a chip, and no disagreement between copies remains after the next enabled edge.
- R7: In the single-column mode, only stage 3 is voted. An upset injected into stage 4 is seen by the voter on the tenth enabled edge after the injection, and no disagreement remains after that edge.
- R8: `mismatch[i]` is high for the cycle that follows an enabled edge at which the copies of lane i disagreed at a voted stage. The voted stages are all stages in the all-stage mode and stage 3 in the single-column mode.
- R9: Each chip is the majority of the three copies of stage 10, so flipping two copies of stage 10 inverts the chip at once.
- R10: The lanes are independent: an upset in one lane never raises another lane's flag or alters its chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset and reload to all ones |
| en | input | 1 | Advance all lanes by one chip |
| upset_inj | input | 120 | One flip request per copy bit, indexed (lane*3+copy)*10+stage-1 |
| chip | output | 4 | Majority-voted stage-10 value per lane |
| mismatch | output | 4 | One-cycle flag per lane: copies disagreed at a voted stage |

## Verification
The chips come straight from the registered copies, so a shift or an injection shows on `chip` in the same cycle that follows the edge that caused it. The bench compares the chips a short delay after each edge against an unprotected reference register. A mismatch flag is due one edge later than the disagreement it reports. The bench therefore predicts each flag from its own model of the error positions before every edge and compares the flag after that edge. In the single-column mode a stage-4 upset is due at the voter on the tenth enabled edge, and the bench counts edges from the injection to confirm it. The reload is checked by permanently corrupting one lane with a double upset and watching the chips return to the reference on the first edge of the next period.

// File: rtl/tmr_gold_pkg.sv
package tmr_gold_pkg;

    // Which stages get a majority voter
    typedef enum logic {
        VOTE_ALL     = 1'b0,
        VOTE_ONE_COL = 1'b1
    } vote_mode_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tmr_gold_epoch.sv
module tmr_gold_epoch #(
    parameter int PERIOD = 1023
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic wrap
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign wrap = (cnt_q == LAST);

    AST_EPOCH_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);                                             // R4
    AST_EPOCH_WRAP: assert property (@(posedge clk) disable iff (rst)
        en && wrap |=> cnt_q == '0);                                // R4

endmodule

// File: rtl/tmr_gold_lane.sv
module tmr_gold_lane
    import tmr_gold_pkg::*;
#(
    parameter int         STAGES     = 10,
    parameter int         FB_TAP     = 3,
    parameter int         VOTE_STAGE = 3,
    parameter vote_mode_e VOTE_MODE  = VOTE_ALL
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  reload,
    input  logic [3*STAGES-1:0]   inj,
    output logic                  chip,
    output logic                  flag
);
    localparam logic [STAGES-1:0] VOTED =
        (VOTE_MODE == VOTE_ALL) ? {STAGES{1'b1}} : (STAGES'(1) << (VOTE_STAGE - 1));

    typedef struct packed {
        logic [2:0][STAGES-1:0] rep;
        logic                   flag;
    } lane_t;

    lane_t d, q;
    logic [STAGES-1:0]      vote;
    logic [2:0][STAGES-1:0] src;
    logic                   disagree;

    always_comb begin
        vote     = '0;
        disagree = 1'b0;
        for (int j = 0; j < STAGES; j++) begin
            vote[j] = maj3(q.rep[0][j], q.rep[1][j], q.rep[2][j]);
            if (VOTED[j]) begin
                disagree = disagree | (q.rep[0][j] ^ q.rep[1][j]) | (q.rep[1][j] ^ q.rep[2][j]);
            end
        end
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < STAGES; j++) begin
                src[k][j] = VOTED[j] ? vote[j] : q.rep[k][j];
            end
        end

        d      = q;
        d.flag = en & disagree;
        if (en) begin
            if (reload) begin
                d.rep = '1;
            end else begin
                for (int k = 0; k < 3; k++) begin
                    d.rep[k] = {src[k][STAGES-2:0], src[k][FB_TAP-1] ^ src[k][STAGES-1]};
                end
            end
        end
        d.rep = d.rep ^ inj;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.rep  <= '1;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign chip = maj3(q.rep[0][STAGES-1], q.rep[1][STAGES-1], q.rep[2][STAGES-1]);
    assign flag = q.flag;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en && inj == '0 |=> $stable(q.rep));                       // R3
    AST_RELOAD_ONES: assert property (@(posedge clk) disable iff (rst)
        en && reload && inj == '0 |=> &q.rep);                      // R4

    if (VOTE_MODE == VOTE_ALL) begin : g_full_chk
        AST_FULL_AGREE: assert property (@(posedge clk) disable iff (rst)
            en && inj == '0 |=> (q.rep[0] == q.rep[1]) && (q.rep[1] == q.rep[2])); // R6
    end else begin : g_col_chk
        AST_COL_AGREE: assert property (@(posedge clk) disable iff (rst)
            en && inj == '0 |=> (q.rep[0][VOTE_STAGE] == q.rep[1][VOTE_STAGE])
                             && (q.rep[1][VOTE_STAGE] == q.rep[2][VOTE_STAGE]));  // R7
    end

endmodule

// File: rtl/tmr_gold_bank.sv
module tmr_gold_bank
    import tmr_gold_pkg::*;
#(
    parameter int         NUM_LFSR   = 4,
    parameter int         STAGES     = 10,
    parameter int         FB_TAP     = 3,
    parameter int         VOTE_STAGE = 3,
    parameter int         PERIOD     = 1023,
    parameter vote_mode_e VOTE_MODE  = VOTE_ALL
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en,
    input  logic [NUM_LFSR*3*STAGES-1:0]   upset_inj,
    output logic [NUM_LFSR-1:0]            chip,
    output logic [NUM_LFSR-1:0]            mismatch
);
    localparam int LANE_W = 3 * STAGES;

    logic wrap;

    tmr_gold_epoch #(.PERIOD(PERIOD)) u_epoch (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .wrap (wrap)
    );

    for (genvar i = 0; i < NUM_LFSR; i++) begin : g_lane
        tmr_gold_lane #(
            .STAGES     (STAGES),
            .FB_TAP     (FB_TAP),
            .VOTE_STAGE (VOTE_STAGE),
            .VOTE_MODE  (VOTE_MODE)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .reload (wrap),
            .inj    (upset_inj[i*LANE_W +: LANE_W]),
            .chip   (chip[i]),
            .flag   (mismatch[i])
        );

        AST_FLAG_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            upset_inj[i*LANE_W +: LANE_W] == '0 && !mismatch[i] && !en
            |=> !mismatch[i]);                                      // R10
    end

endmodule

// File: tb/tb_tmr_gold_bank.sv
module tb_tmr_gold_bank;
    import tmr_gold_pkg::*;

    localparam int NL  = 4;
    localparam int NS  = 10;
    localparam int IW  = NL * 3 * NS;
    localparam int PER = 1023;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [IW-1:0] inj_f = '0;
    logic [IW-1:0] inj_s = '0;
    logic [NL-1:0] chip_f, chip_s, flag_f, flag_s;

    always #5 clk = ~clk;

    tmr_gold_bank #(.VOTE_MODE(VOTE_ALL)) dut (
        .clk(clk), .rst(rst), .en(en), .upset_inj(inj_f), .chip(chip_f), .mismatch(flag_f));
    tmr_gold_bank #(.VOTE_MODE(VOTE_ONE_COL)) dut_sc (
        .clk(clk), .rst(rst), .en(en), .upset_inj(inj_s), .chip(chip_s), .mismatch(flag_s));

    int checks = 0;
    int errors = 0;

    logic [NS-1:0] refm [NL];
    logic [NS-1:0] errm [2][NL][3];
    bit            bad  [2];
    int            sc;
    logic [NL-1:0] exp_flag [2];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] ref_step(input logic [NS-1:0] s);
        return {s[NS-2:0], s[2] ^ s[NS-1]};
    endfunction

    function automatic logic [NL-1:0] ref_chips();
        logic [NL-1:0] c;
        for (int l = 0; l < NL; l++) c[l] = refm[l][NS-1];
        return c;
    endfunction

    function automatic bit lane_clean(input int m, input int l);
        return (errm[m][l][0] == '0) && (errm[m][l][1] == '0) && (errm[m][l][2] == '0);
    endfunction

    task automatic model_reset();
        for (int l = 0; l < NL; l++) begin
            refm[l] = '1;
            for (int m = 0; m < 2; m++)
                for (int k = 0; k < 3; k++) errm[m][l][k] = '0;
        end
        bad[0] = 1'b0;
        bad[1] = 1'b0;
        sc = 0;
    endtask

    // One clock: predict, take the edge, update the model, sample 2 ns later
    task automatic tick();
        bit reload;
        logic [NS-1:0] diff;
        logic [NS-1:0] e;
        if (rst) begin
            model_reset();
            exp_flag[0] = '0;
            exp_flag[1] = '0;
            @(posedge clk);
        end else begin
            for (int m = 0; m < 2; m++)
                for (int l = 0; l < NL; l++) begin
                    diff = (errm[m][l][0] ^ errm[m][l][1]) | (errm[m][l][1] ^ errm[m][l][2]);
                    exp_flag[m][l] = en && ((m == 0) ? (|diff) : diff[2]);
                end
            @(posedge clk);
            if (en) begin
                reload = (sc == PER - 1);
                for (int l = 0; l < NL; l++) begin
                    refm[l] = reload ? '1 : ref_step(refm[l]);
                    for (int k = 0; k < 3; k++) begin
                        errm[0][l][k] = '0;
                        e = errm[1][l][k];
                        errm[1][l][k] = reload ? '0 : {e[NS-2:3], 1'b0, e[1:0], e[NS-1]};
                    end
                end
                if (reload) begin
                    bad[0] = 1'b0;
                    bad[1] = 1'b0;
                end
                sc = reload ? 0 : sc + 1;
            end
            for (int l = 0; l < NL; l++)
                for (int k = 0; k < 3; k++)
                    for (int j = 0; j < NS; j++) begin
                        errm[0][l][k][j] = errm[0][l][k][j] ^ inj_f[(l*3+k)*NS+j];
                        errm[1][l][k][j] = errm[1][l][k][j] ^ inj_s[(l*3+k)*NS+j];
                    end
        end
        #2;
        if (!bad[0]) chk(chip_f == ref_chips(), "R6", "all-stage chips", 32'(chip_f), 32'(ref_chips()));
        if (!bad[1]) chk(chip_s == ref_chips(), "R7", "one-column chips", 32'(chip_s), 32'(ref_chips()));
        chk(flag_f == exp_flag[0], "R8", "all-stage flags", 32'(flag_f), 32'(exp_flag[0]));
        chk(flag_s == exp_flag[1], "R8", "one-column flags", 32'(flag_s), 32'(exp_flag[1]));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en  = 1'b0;
        inj_f = '0;
        inj_s = '0;
        repeat (2) tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [NL-1:0] held;
        int n_hit;
        int l, k, j;
        void'($urandom(32'd4711));

        // R1: reset state
        do_reset();
        tick();
        chk(chip_f == 4'hF && chip_s == 4'hF, "R1", "chips after reset", 32'({chip_f, chip_s}), 32'hFF);
        chk(flag_f == '0 && flag_s == '0, "R1", "flags after reset", 32'({flag_f, flag_s}), 32'h0);

        // R2 and R3: run, then hold with en low
        en = 1'b1;
        repeat (20) tick();
        chk(chip_f == ref_chips(), "R2", "recurrence after 20 shifts", 32'(chip_f), 32'(ref_chips()));
        en = 1'b0;
        held = chip_f;
        repeat (5) tick();
        chk(chip_f == held && chip_s == held, "R3", "chips hold while idle", 32'({chip_f, chip_s}), 32'({held, held}));
        chk(flag_f == '0 && flag_s == '0, "R3", "no flag while idle", 32'({flag_f, flag_s}), 32'h0);

        // R5 / R10: one upset in lane 1, copy 2, stage 6 of the all-stage bank
        en = 1'b1;
        inj_f[(1*3+2)*NS+5] = 1'b1;
        tick();
        inj_f = '0;
        tick();
        chk(flag_f == 4'b0010, "R5", "flag from addressed copy bit", 32'(flag_f), 32'h2);
        chk(flag_f[0] == 1'b0 && flag_f[3:2] == 2'b00, "R10", "other lanes quiet", 32'(flag_f), 32'h2);
        tick();
        chk(flag_f == '0, "R6", "upset scrubbed after one edge", 32'(flag_f), 32'h0);

        // R7: stage-4 upset in the one-column bank reaches the voter on edge 10
        inj_s[(3*3+1)*NS+3] = 1'b1;
        tick();
        inj_s = '0;
        n_hit = 0;
        for (int t = 1; t <= 15; t++) begin
            tick();
            if (n_hit == 0 && flag_s[3]) n_hit = t;
        end
        chk(n_hit == 10, "R7", "edges until voter sees stage-4 upset", 32'(n_hit), 32'd10);
        repeat (12) tick();
        chk(flag_s == '0 && lane_clean(1, 3), "R7", "one-column lane scrubbed", 32'(flag_s), 32'h0);

        // Random phase: single upsets and idle cycles
        for (int t = 0; t < 3000; t++) begin
            en = ($urandom_range(0, 7) != 0);
            inj_f = '0;
            inj_s = '0;
            if ($urandom_range(0, 5) == 0) begin
                l = $urandom_range(0, NL-1); k = $urandom_range(0, 2); j = $urandom_range(0, NS-1);
                if (lane_clean(0, l)) inj_f[(l*3+k)*NS+j] = 1'b1;
            end
            if ($urandom_range(0, 5) == 0) begin
                l = $urandom_range(0, NL-1); k = $urandom_range(0, 2); j = $urandom_range(0, NS-1);
                if (lane_clean(1, l)) inj_s[(l*3+k)*NS+j] = 1'b1;
            end
            tick();
        end
        inj_f = '0;
        inj_s = '0;

        // R9 and R4: double upset at stage 10 corrupts lane 0 until the period reload
        do_reset();
        en = 1'b1;
        repeat (100) tick();
        inj_f[(0*3+0)*NS+9] = 1'b1;
        inj_f[(0*3+1)*NS+9] = 1'b1;
        bad[0] = 1'b1;
        tick();
        inj_f = '0;
        chk(chip_f[0] == ~refm[0][NS-1], "R9", "two copies flipped invert chip", 32'(chip_f[0]), 32'(~refm[0][NS-1]));
        while (sc != 0) begin
            en = ($urandom_range(0, 3) != 0);
            tick();
        end
        chk(chip_f == 4'hF, "R4", "reload to all ones", 32'(chip_f), 32'hF);
        en = 1'b1;
        repeat (30) tick();
        chk(chip_f == ref_chips(), "R4", "sequence resumes after reload", 32'(chip_f), 32'(ref_chips()));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule